// File: doc/BRIEF.md
# PFM Mode Controller

This block decides, for one switching channel, when to leave fixed-frequency PWM regulation for pulse-frequency operation at light load, and when to go back. While in PWM it counts consecutive switching cycles in which the sampled load-current code stays under a programmed limit. Once that run reaches the programmed length, the block switches the channel into PFM. The PWM loop is then to be held off, and output voltage is regulated by comparing codes against a three-level window.

In PFM the scaled output-voltage code is compared against the reference and against an upper and a lower edge. Each edge is offset from the reference by a programmable fraction of the reference, so the window moves with it. A drop below the reference requests one switching burst from the gate driver through a single-clock trigger. Leaving the window through either outer edge returns the channel to PWM and emits a single-clock exit pulse. The block also supplies the on-time duty code for PFM bursts. The first burst uses the last PWM duty, and later bursts use the ratio of output voltage to supply voltage.

All comparisons are made digitally on codes. The converters, the PWM loop and the power stage are outside this block.

Top module: `pfm_mode_ctrl`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `pfmMode`, `trigPulse` and `exitPulse` are 0 and `pfmDuty` is 0.
- R2: In PWM (`pfmMode`=0), the Nth consecutive `cycleStb` seen while `iCode` < `cfgIthr` makes `pfmMode` read 1 from the next clock on. Here N is the active cycle count.
- R3: In PWM, any clock with `iCode` >= `cfgIthr` clears the run, whether or not a strobe is present, so that N fresh strobes are needed again.
- R4: A `cfgCycles` value of 0 selects the default cycle count `DEFAULT_CYCLES` (20). Any other value is used as N directly.
- R5: The upper edge is `vrefCode + floor(vrefCode*cfgHighPct/128)` and the lower edge is `vrefCode - floor(vrefCode*cfgLowPct/128)`. A voltage equal to an edge is inside the window.
- R6: In PFM, `voutCode` < `vrefCode` (inside the window) raises `trigPulse` for exactly one clock, on the next clock. No further trigger is issued until `voutCode` >= `vrefCode` has been seen. The channel is armed on entry.
- R7: In PFM, `voutCode` above the upper edge or below the lower edge makes `pfmMode` read 0 and `exitPulse` read 1 for one clock on the next clock. An exit takes priority over a trigger in the same cycle.
- R8: After an exit, the qualification run starts from zero, and a full run of N strobes is needed to enter PFM again.
- R9: In PWM, `pfmDuty` equals the `pwmDuty` of the previous clock. The first trigger after entry therefore carries the PWM duty present in the entry cycle.
- R10: On the clock after each trigger, `pfmDuty` is loaded with `min(floor(voutCode*256/vccCode), 255)`, taking `voutCode` and `vccCode` from the cycle in which `trigPulse` is 1. A `vccCode` of 0 gives 255.
- R11: In PWM, `trigPulse` and `exitPulse` stay 0 whatever the voltage codes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycleStb | input | 1 | One-clock strobe per switching cycle |
| iCode | input | CODE_W | Sampled output-current code |
| voutCode | input | CODE_W | Scaled output-voltage code |
| vrefCode | input | CODE_W | Reference voltage code |
| vccCode | input | CODE_W | Input supply voltage code, same scale as voutCode |
| cfgIthr | input | CODE_W | Light-load current limit |
| cfgCycles | input | CNT_W | Qualification cycle count, 0 selects default |
| cfgHighPct | input | PCT_W | Upper window offset in 1/128 of reference |
| cfgLowPct | input | PCT_W | Lower window offset in 1/128 of reference |
| pwmDuty | input | DUTY_W | Duty code currently used by the PWM loop |
| pfmMode | output | 1 | 1 while the channel is in PFM |
| trigPulse | output | 1 | One-clock request for a switching burst |
| exitPulse | output | 1 | One-clock marker of a return to PWM |
| pfmDuty | output | DUTY_W | Duty code for PFM bursts |

## Verification
The bench builds the block with its default parameters: 10-bit codes, an 8-bit counter, 7-bit percentages, an 8-bit duty and a default count of 20. With these values the default count fits in the counter, a 127/128 offset pulls the lower edge to within a few codes of zero, and the voltage-to-supply ratio overflows the 8-bit duty range, so the saturation path is exercised. A `cfgCycles` of 1 exercises the shortest possible entry, in which the first qualifying strobe enters PFM.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PFM = 1'b1
  } modeE;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;   // restart the light-load run
    logic cntInc;     // one more qualifying cycle
    logic dutyTrack;  // follow the PWM duty
    logic dutyRatio;  // load the vout/vcc ratio
  } ctlStrobesT;

endpackage

// File: rtl/pfm_offset.sv
// Window offset: floor(ref * pct / 2^PCT_W)
module pfm_offset #(
  parameter int CODE_W = 10,
  parameter int PCT_W  = 7
) (
  input  logic [CODE_W-1:0] refCode,
  input  logic [PCT_W-1:0]  pct,
  output logic [CODE_W-1:0] offset
);
  localparam int PROD_W = CODE_W + PCT_W;

  logic [PROD_W-1:0] product;

  always_comb begin
    product = PROD_W'(refCode) * PROD_W'(pct);
    offset  = product[PROD_W-1:PCT_W];
  end
endmodule

// File: rtl/pfm_datapath.sv
module pfm_datapath
  import pfm_pkg::*;
#(
  parameter int CODE_W         = 10,
  parameter int CNT_W          = 8,
  parameter int PCT_W          = 7,
  parameter int DUTY_W         = 8,
  parameter int DEFAULT_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobesT        ctl,
  input  logic [CODE_W-1:0] iCode,
  input  logic [CODE_W-1:0] voutCode,
  input  logic [CODE_W-1:0] vrefCode,
  input  logic [CODE_W-1:0] vccCode,
  input  logic [CODE_W-1:0] cfgIthr,
  input  logic [CNT_W-1:0]  cfgCycles,
  input  logic [PCT_W-1:0]  cfgHighPct,
  input  logic [PCT_W-1:0]  cfgLowPct,
  input  logic [DUTY_W-1:0] pwmDuty,
  output logic              curLow,
  output logic              cntReached,
  output logic              outOfWindow,
  output logic              belowRef,
  output logic [DUTY_W-1:0] dutyQ
);
  localparam int THR_W = CODE_W + 1;
  localparam int NUM_W = CODE_W + DUTY_W;
  localparam logic [CNT_W-1:0]  DEF_CNT  = CNT_W'(DEFAULT_CYCLES);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  // window edges: index 0 = upper, 1 = lower
  logic [CODE_W-1:0] edgeOffset [2];
  logic [PCT_W-1:0]  edgePct    [2];

  assign edgePct[0] = cfgHighPct;
  assign edgePct[1] = cfgLowPct;

  for (genvar e = 0; e < 2; e++) begin : g_edge
    pfm_offset #(
      .CODE_W(CODE_W),
      .PCT_W (PCT_W)
    ) u_offset (
      .refCode(vrefCode),
      .pct    (edgePct[e]),
      .offset (edgeOffset[e])
    );
  end

  logic [THR_W-1:0] hiThr;
  logic [THR_W-1:0] loThr;
  logic [THR_W-1:0] voutWide;

  always_comb begin
    voutWide    = THR_W'(voutCode);
    hiThr       = THR_W'(vrefCode) + THR_W'(edgeOffset[0]);
    loThr       = THR_W'(vrefCode) - THR_W'(edgeOffset[1]);
    outOfWindow = (voutWide > hiThr) || (voutWide < loThr);
    belowRef    = voutCode < vrefCode;
    curLow      = iCode < cfgIthr;
  end

  // qualification counter
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] target;

  always_comb begin
    target     = (cfgCycles == '0) ? DEF_CNT : cfgCycles;
    cntReached = cntQ >= (target - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (ctl.cntClear) begin
      cntQ <= '0;
    end else if (ctl.cntInc && cntQ != CNT_MAX) begin
      cntQ <= cntQ + CNT_W'(1);
    end
  end

  // duty from vout/vcc
  logic [NUM_W-1:0]  numer;
  logic [NUM_W-1:0]  quot;
  logic [DUTY_W-1:0] ratio;

  always_comb begin
    numer = {voutCode, {DUTY_W{1'b0}}};
    quot  = (vccCode == '0) ? '0 : numer / NUM_W'(vccCode);
    if (vccCode == '0 || quot > NUM_W'(DUTY_MAX)) begin
      ratio = DUTY_MAX;
    end else begin
      ratio = quot[DUTY_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dutyQ <= '0;
    end else if (ctl.dutyTrack) begin
      dutyQ <= pwmDuty;
    end else if (ctl.dutyRatio) begin
      dutyQ <= ratio;
    end
  end
endmodule

// File: rtl/pfm_control.sv
module pfm_control
  import pfm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycleStb,
  input  logic       curLow,
  input  logic       cntReached,
  input  logic       outOfWindow,
  input  logic       belowRef,
  output ctlStrobesT ctl,
  output logic       pfmMode,
  output logic       trigPulse,
  output logic       exitPulse
);
  modeE modeQ, modeN;
  logic armedQ, armedN;
  logic trigQ, trigN;
  logic exitQ, exitN;

  always_comb begin
    modeN  = modeQ;
    armedN = armedQ;
    trigN  = 1'b0;
    exitN  = 1'b0;
    ctl    = '0;
    unique case (modeQ)
      MODE_PWM: begin
        ctl.dutyTrack = 1'b1;
        if (!curLow) begin
          ctl.cntClear = 1'b1;
        end else if (cycleStb) begin
          if (cntReached) begin
            modeN        = MODE_PFM;
            armedN       = 1'b1;
            ctl.cntClear = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      MODE_PFM: begin
        ctl.cntClear  = 1'b1;
        ctl.dutyRatio = trigQ;
        if (outOfWindow) begin
          modeN  = MODE_PWM;
          exitN  = 1'b1;
          armedN = 1'b0;
        end else if (belowRef) begin
          if (armedQ) begin
            trigN  = 1'b1;
            armedN = 1'b0;
          end
        end else begin
          armedN = 1'b1;
        end
      end
      default: modeN = MODE_PWM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_PWM;
      armedQ <= 1'b0;
      trigQ  <= 1'b0;
      exitQ  <= 1'b0;
    end else begin
      modeQ  <= modeN;
      armedQ <= armedN;
      trigQ  <= trigN;
      exitQ  <= exitN;
    end
  end

  assign pfmMode   = (modeQ == MODE_PFM);
  assign trigPulse = trigQ;
  assign exitPulse = exitQ;
endmodule

// File: rtl/pfm_mode_ctrl.sv
module pfm_mode_ctrl
  import pfm_pkg::*;
#(
  parameter int CODE_W         = 10,
  parameter int CNT_W          = 8,
  parameter int PCT_W          = 7,
  parameter int DUTY_W         = 8,
  parameter int DEFAULT_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycleStb,
  input  logic [CODE_W-1:0] iCode,
  input  logic [CODE_W-1:0] voutCode,
  input  logic [CODE_W-1:0] vrefCode,
  input  logic [CODE_W-1:0] vccCode,
  input  logic [CODE_W-1:0] cfgIthr,
  input  logic [CNT_W-1:0]  cfgCycles,
  input  logic [PCT_W-1:0]  cfgHighPct,
  input  logic [PCT_W-1:0]  cfgLowPct,
  input  logic [DUTY_W-1:0] pwmDuty,
  output logic              pfmMode,
  output logic              trigPulse,
  output logic              exitPulse,
  output logic [DUTY_W-1:0] pfmDuty
);
  ctlStrobesT ctl;
  logic curLow;
  logic cntReached;
  logic outOfWindow;
  logic belowRef;

  pfm_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cycleStb   (cycleStb),
    .curLow     (curLow),
    .cntReached (cntReached),
    .outOfWindow(outOfWindow),
    .belowRef   (belowRef),
    .ctl        (ctl),
    .pfmMode    (pfmMode),
    .trigPulse  (trigPulse),
    .exitPulse  (exitPulse)
  );

  pfm_datapath #(
    .CODE_W        (CODE_W),
    .CNT_W         (CNT_W),
    .PCT_W         (PCT_W),
    .DUTY_W        (DUTY_W),
    .DEFAULT_CYCLES(DEFAULT_CYCLES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .iCode      (iCode),
    .voutCode   (voutCode),
    .vrefCode   (vrefCode),
    .vccCode    (vccCode),
    .cfgIthr    (cfgIthr),
    .cfgCycles  (cfgCycles),
    .cfgHighPct (cfgHighPct),
    .cfgLowPct  (cfgLowPct),
    .pwmDuty    (pwmDuty),
    .curLow     (curLow),
    .cntReached (cntReached),
    .outOfWindow(outOfWindow),
    .belowRef   (belowRef),
    .dutyQ      (pfmDuty)
  );
endmodule

// File: rtl/pfm_mode_ctrl_sva.sv
module pfm_mode_ctrl_sva #(
  parameter int CODE_W = 10,
  parameter int CNT_W  = 8,
  parameter int PCT_W  = 7,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycleStb,
  input logic [CODE_W-1:0] iCode,
  input logic [CODE_W-1:0] voutCode,
  input logic [CODE_W-1:0] vrefCode,
  input logic [CODE_W-1:0] cfgIthr,
  input logic [PCT_W-1:0]  cfgHighPct,
  input logic [PCT_W-1:0]  cfgLowPct,
  input logic [DUTY_W-1:0] pwmDuty,
  input logic              pfmMode,
  input logic              trigPulse,
  input logic              exitPulse,
  input logic [DUTY_W-1:0] pfmDuty
);
  int hiEdge;
  int loEdge;
  logic outside;

  always_comb begin
    hiEdge  = int'(vrefCode) + (int'(vrefCode) * int'(cfgHighPct)) / (1 << PCT_W);
    loEdge  = int'(vrefCode) - (int'(vrefCode) * int'(cfgLowPct)) / (1 << PCT_W);
    outside = (int'(voutCode) > hiEdge) || (int'(voutCode) < loEdge);
  end

  assert_entry_qualified_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfmMode) |-> $past(cycleStb && (iCode < cfgIthr)));

  assert_trig_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |=> !trigPulse);

  assert_trig_below_ref_R6: assert property (@(posedge clk) disable iff (!rstN)
    trigPulse |-> $past(pfmMode && (voutCode < vrefCode)));

  assert_exit_on_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    (pfmMode && outside) |=> (!pfmMode && exitPulse && !trigPulse));

  assert_exit_marks_fall_R7: assert property (@(posedge clk) disable iff (!rstN)
    exitPulse |-> (!pfmMode && $past(pfmMode)));

  assert_duty_tracks_R9: assert property (@(posedge clk) disable iff (!rstN)
    !pfmMode |=> (pfmDuty == $past(pwmDuty)));

  assert_quiet_in_pwm_R11: assert property (@(posedge clk) disable iff (!rstN)
    !pfmMode |=> !trigPulse);
endmodule

bind pfm_mode_ctrl pfm_mode_ctrl_sva #(
  .CODE_W(CODE_W),
  .CNT_W (CNT_W),
  .PCT_W (PCT_W),
  .DUTY_W(DUTY_W)
) u_sva (
  .clk       (clk),
  .rstN      (rstN),
  .cycleStb  (cycleStb),
  .iCode     (iCode),
  .voutCode  (voutCode),
  .vrefCode  (vrefCode),
  .cfgIthr   (cfgIthr),
  .cfgHighPct(cfgHighPct),
  .cfgLowPct (cfgLowPct),
  .pwmDuty   (pwmDuty),
  .pfmMode   (pfmMode),
  .trigPulse (trigPulse),
  .exitPulse (exitPulse),
  .pfmDuty   (pfmDuty)
);

// File: tb/tb_pfm_mode_ctrl.sv
module tb_pfm_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 10;
  localparam int CNT_W  = 8;
  localparam int PCT_W  = 7;
  localparam int DUTY_W = 8;
  localparam int WATCHDOG = 100000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cycleStb = 1'b0;
  logic [CODE_W-1:0] iCode = '0;
  logic [CODE_W-1:0] voutCode = '0;
  logic [CODE_W-1:0] vrefCode = '0;
  logic [CODE_W-1:0] vccCode = '0;
  logic [CODE_W-1:0] cfgIthr = '0;
  logic [CNT_W-1:0]  cfgCycles = '0;
  logic [PCT_W-1:0]  cfgHighPct = '0;
  logic [PCT_W-1:0]  cfgLowPct = '0;
  logic [DUTY_W-1:0] pwmDuty = '0;
  logic              pfmMode;
  logic              trigPulse;
  logic              exitPulse;
  logic [DUTY_W-1:0] pfmDuty;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfm_mode_ctrl dut (
    .clk(clk), .rstN(rstN), .cycleStb(cycleStb), .iCode(iCode),
    .voutCode(voutCode), .vrefCode(vrefCode), .vccCode(vccCode),
    .cfgIthr(cfgIthr), .cfgCycles(cfgCycles), .cfgHighPct(cfgHighPct),
    .cfgLowPct(cfgLowPct), .pwmDuty(pwmDuty), .pfmMode(pfmMode),
    .trigPulse(trigPulse), .exitPulse(exitPulse), .pfmDuty(pfmDuty)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  string phase = "R1";

  // reference model state
  int mMode = 0, mCnt = 0, mArmed = 0, mTrig = 0, mExit = 0, mDuty = 0;

  function automatic int ratioOf(int v, int s);
    int q;
    if (s == 0) return 255;
    q = (v * 256) / s;
    return (q > 255) ? 255 : q;
  endfunction

  task automatic modelEdge();
    int target, hi, lo, v, r;
    int nMode, nCnt, nArmed, nTrig, nExit, nDuty;
    if (!rstN) begin
      mMode = 0; mCnt = 0; mArmed = 0; mTrig = 0; mExit = 0; mDuty = 0;
      return;
    end
    target = (cfgCycles == 0) ? 20 : int'(cfgCycles);
    r  = int'(vrefCode);
    v  = int'(voutCode);
    hi = r + (r * int'(cfgHighPct)) / 128;
    lo = r - (r * int'(cfgLowPct)) / 128;
    nMode = mMode; nCnt = mCnt; nArmed = mArmed; nTrig = 0; nExit = 0; nDuty = mDuty;
    if (mMode == 0) begin
      nDuty = int'(pwmDuty);
      if (iCode >= cfgIthr) nCnt = 0;
      else if (cycleStb) begin
        if (mCnt + 1 >= target) begin
          nMode = 1; nCnt = 0; nArmed = 1;
        end else nCnt = (mCnt < 255) ? mCnt + 1 : 255;
      end
    end else begin
      nCnt = 0;
      if (mTrig != 0) nDuty = ratioOf(v, int'(vccCode));
      if (v > hi || v < lo) begin
        nMode = 0; nExit = 1; nArmed = 0;
      end else if (v < r) begin
        if (mArmed != 0) begin nTrig = 1; nArmed = 0; end
      end else nArmed = 1;
    end
    mMode = nMode; mCnt = nCnt; mArmed = nArmed; mTrig = nTrig; mExit = nExit; mDuty = nDuty;
  endtask

  task automatic checkOne(string what, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s got %0d expected %0d at cycle %0d", phase, what, got, exp, cycles);
    end
  endtask

  // one clock: model sees the inputs the DUT sees at the edge, compare after it
  task automatic step();
    modelEdge();
    @(posedge clk);
    cycles++;
    @(negedge clk);
    checkOne("pfmMode",   int'(pfmMode),   mMode);
    checkOne("trigPulse", int'(trigPulse), mTrig);
    checkOne("exitPulse", int'(exitPulse), mExit);
    checkOne("pfmDuty",   int'(pfmDuty),   mDuty);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic strobe();
    cycleStb = 1'b1;
    step();
    cycleStb = 1'b0;
    step();
    step();
  endtask

  task automatic expectMode(int exp);
    checkOne("pfmMode(direct)", int'(pfmMode), exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    vrefCode = 10'd512; voutCode = 10'd512; vccCode = 10'd700;
    cfgIthr = 10'd100; iCode = 10'd300; cfgCycles = 8'd0;
    cfgHighPct = 7'd13; cfgLowPct = 7'd10; pwmDuty = 8'd90;
    @(negedge clk);
    phase = "R1";
    steps(4);
    rstN = 1'b1;
    steps(2);

    // R11: PWM ignores voltages outside the window and below reference
    phase = "R11";
    voutCode = 10'd400; steps(3);
    voutCode = 10'd700; steps(3);
    voutCode = 10'd512;

    // R4 / R2: default count of 20 strobes
    phase = "R4";
    iCode = 10'd50;
    for (int i = 0; i < 19; i++) strobe();
    expectMode(0);
    // R9: duty follows PWM each cycle
    phase = "R9";
    for (int i = 0; i < 4; i++) begin pwmDuty = DUTY_W'(100 + i); step(); end
    phase = "R2";
    pwmDuty = 8'd120;
    strobe();
    expectMode(1);
    pwmDuty = 8'd33;

    // R6 / R10: triggers and duty recomputation
    phase = "R6";
    voutCode = 10'd500; steps(5);
    voutCode = 10'd520; steps(2);
    phase = "R10";
    vccCode = 10'd700; voutCode = 10'd500; steps(4);
    voutCode = 10'd512; steps(2);
    vccCode = 10'd0; voutCode = 10'd490; steps(3);
    voutCode = 10'd530; steps(2);
    vccCode = 10'd400; voutCode = 10'd510; steps(3);
    vccCode = 10'd700; voutCode = 10'd512; steps(2);

    // R5 / R7: upper edge inclusive, one past exits
    phase = "R5";
    voutCode = 10'd564; steps(3);
    phase = "R7";
    voutCode = 10'd565; steps(3);
    voutCode = 10'd512; steps(2);

    // R3 / R8: re-entry needs a full new run; a high-current cycle restarts it
    phase = "R8";
    cfgCycles = 8'd5;
    for (int i = 0; i < 3; i++) strobe();
    phase = "R3";
    iCode = 10'd150; step();
    iCode = 10'd50;
    for (int i = 0; i < 4; i++) strobe();
    expectMode(0);
    strobe();
    expectMode(1);

    // R7: lower edge inclusive, exit beats trigger
    phase = "R7";
    voutCode = 10'd472; steps(3);
    voutCode = 10'd512; steps(2);
    voutCode = 10'd470; steps(3);
    expectMode(0);

    // R5: near-full offsets, shortest run
    phase = "R5";
    vrefCode = 10'd300; voutCode = 10'd300;
    cfgHighPct = 7'd127; cfgLowPct = 7'd127; cfgCycles = 8'd1;
    strobe();
    expectMode(1);
    voutCode = 10'd597; steps(2);
    voutCode = 10'd3;   steps(3);
    voutCode = 10'd300; steps(2);
    voutCode = 10'd598; steps(3);
    voutCode = 10'd300;
    strobe();
    voutCode = 10'd2; steps(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule